// File: doc/BRIEF.md
# SUBLEQ Processor Core

A 16-bit processor that knows a single instruction: subtract, and branch when the result is zero or negative. Code and data share one word-addressed memory. Every instruction occupies three consecutive words, `a`, `b` and `c`. The core reads both operands through `a` and `b`, writes `mem[b] - mem[a]` back to `mem[b]`, and continues at `c` when that result is not positive. The memory port is synchronous and has one cycle of read latency. The core drives the address and write data, and the read data comes back on the following cycle.

Operand value -1 selects byte I/O. With `a` at -1 the core waits for an input byte and stores it, zero-extended, at `mem[b]`. With `b` at -1 (and `a` not -1) it waits until the output side is free and emits the low byte of `mem[a]`. Each I/O instruction gives exactly one single-cycle handshake pulse. A `pause` input holds the core before its next fetch. When the program counter is negative at fetch time, the core halts for good, until reset. The `blocked` output shows that the core is stalled on pause, input or output. The `halted` output shows that the core has stopped.

Top module: `oisc_core`

## Requirements
- R1: While reset is applied and after its release, `halted`, `blocked`, `mem_we`, `in_ack` and `out_we` are low, and the first memory address presented is 0.
- R2: For an instruction with neither operand at -1, `mem[b]` becomes `mem[b] - mem[a]` modulo 2^16, and `mem[a]` is unchanged.
- R3: When that difference is zero or has bit 15 set, execution continues at `c`. Otherwise it continues at the instruction three words on.
- R4: When `a` is 0xFFFF, the input byte is written to `mem[b]` with bits 15..8 cleared. `in_ack` pulses for exactly one cycle, and execution continues three words on with no branch.
- R5: When `b` is 0xFFFF and `a` is not, `out_byte` carries bits 7..0 of `mem[a]` while `out_we` pulses for exactly one cycle. No memory write and no branch occur.
- R6: When the program counter has bit 15 set at fetch time, `halted` rises and stays high until reset, and no further memory write, `in_ack` or `out_we` occurs.
- R7: While `pause` is high at fetch time, the core stays at that fetch, with `blocked` high, no memory write and the fetch address held.
- R8: While an input instruction sees `in_valid` low, the core stalls with `blocked` high and `in_ack` low.
- R9: While an output instruction sees `out_busy` high, the core stalls with `blocked` high and `out_we` low.
- R10: When `pause` is high in the same cycle that a negative program counter reaches fetch, the pause wins, and `halted` rises only after `pause` falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | 16 | Word address for the read or the write |
| mem_wdata | output | 16 | Data written when `mem_we` is high |
| mem_we | output | 1 | Memory write enable |
| mem_rdata | input | 16 | Read data for the address of the previous cycle |
| in_byte | input | 8 | Input byte |
| in_valid | input | 1 | Input byte is available |
| in_ack | output | 1 | Input byte consumed (one-cycle pulse) |
| out_byte | output | 8 | Output byte |
| out_busy | input | 1 | Output side cannot accept a byte |
| out_we | output | 1 | Output byte strobe (one-cycle pulse) |
| pause | input | 1 | Hold the core before its next fetch |
| halted | output | 1 | Core has stopped |
| blocked | output | 1 | Core is stalled on pause, input or output |

## Verification
The pause request and the halt decision are both taken in the fetch state, so they can land in the same cycle. The bench provokes this with a program whose first instruction branches to -1. It raises `pause` on the falling edge at which the branch write is visible, so that the negative program counter and the pause meet at the next fetch. The bench judges the outcome by requiring `halted` to stay low and `blocked` to stay high for the whole pause, and then requiring `halted` to rise only after `pause` is released.

// File: rtl/oisc_pkg.sv
package oisc_pkg;
  typedef enum logic [3:0] {
    ST_FA,     // present pc, decide pause or halt
    ST_FB,     // capture a, present pc+1
    ST_FC,     // capture b, present pc+2, advance pc
    ST_LA,     // capture c, present a
    ST_LB,     // capture mem[a], present b
    ST_STORE,  // form difference with mem[b]
    ST_JMP,    // write difference, take branch
    ST_NJMP,   // write difference, fall through
    ST_IN,     // wait for and store input byte
    ST_OUT,    // wait for and emit output byte
    ST_HALT
  } state_e;
endpackage

// File: rtl/oisc_sub.sv
module oisc_sub #(
  parameter int DW = 16
) (
  input  logic [DW-1:0] minuend,
  input  logic [DW-1:0] subtrahend,
  output logic [DW-1:0] diff,
  output logic          le_zero
);
  always_comb begin
    diff    = minuend - subtrahend;
    le_zero = diff[DW-1] | (diff == '0);
  end
endmodule

// File: rtl/oisc_seq.sv
module oisc_seq
  import oisc_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   pause,
  input  logic   pc_neg,
  input  logic   a_neg1,
  input  logic   b_neg1,
  input  logic   diff_le,
  input  logic   in_valid,
  input  logic   out_busy,
  output state_e state,
  output logic   in_ack,
  output logic   out_we,
  output logic   blocked,
  output logic   halted
);
  state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_FA:    if (pause)       state_d = ST_FA;
                else if (pc_neg) state_d = ST_HALT;
                else             state_d = ST_FB;
      ST_FB:    state_d = ST_FC;
      ST_FC:    state_d = a_neg1 ? ST_IN : ST_LA;
      ST_LA:    state_d = ST_LB;
      ST_LB:    state_d = b_neg1 ? ST_OUT : ST_STORE;
      ST_STORE: state_d = diff_le ? ST_JMP : ST_NJMP;
      ST_JMP:   state_d = ST_FA;
      ST_NJMP:  state_d = ST_FA;
      ST_IN:    state_d = in_valid ? ST_FA : ST_IN;
      ST_OUT:   state_d = out_busy ? ST_OUT : ST_FA;
      ST_HALT:  state_d = ST_HALT;
      default:  state_d = ST_HALT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_FA;
    else        state_q <= state_d;
  end

  always_comb begin
    state   = state_q;
    in_ack  = (state_q == ST_IN) & in_valid;
    out_we  = (state_q == ST_OUT) & ~out_busy;
    halted  = (state_q == ST_HALT);
    blocked = ((state_q == ST_FA) & pause) |
              ((state_q == ST_IN) & ~in_valid) |
              ((state_q == ST_OUT) & out_busy);
  end
endmodule

// File: rtl/oisc_datapath.sv
module oisc_datapath
  import oisc_pkg::*;
#(
  parameter int DW = 16,
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  state_e        state,
  input  logic [DW-1:0] mem_rdata,
  input  logic [BW-1:0] in_byte,
  input  logic          in_valid,
  input  logic [DW-1:0] diff,
  output logic [DW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_we,
  output logic [DW-1:0] mem_a_val,
  output logic [BW-1:0] out_byte,
  output logic          pc_neg,
  output logic          a_neg1,
  output logic          b_neg1
);
  localparam int PAD = DW - BW;

  logic [DW-1:0] pc_q, pc_d, a_q, b_q, c_q, ma_q, res_q;
  logic          pc_en;

  always_comb begin
    pc_en = 1'b0;
    pc_d  = pc_q;
    if (state == ST_FC) begin
      pc_en = 1'b1;
      pc_d  = pc_q + DW'(3);
    end else if (state == ST_JMP) begin
      pc_en = 1'b1;
      pc_d  = c_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= '0;
      a_q   <= '0;
      b_q   <= '0;
      c_q   <= '0;
      ma_q  <= '0;
      res_q <= '0;
    end else begin
      if (pc_en)              pc_q  <= pc_d;
      if (state == ST_FB)     a_q   <= mem_rdata;
      if (state == ST_FC)     b_q   <= mem_rdata;
      if (state == ST_LA)     c_q   <= mem_rdata;
      if (state == ST_LB)     ma_q  <= mem_rdata;
      if (state == ST_STORE)  res_q <= diff;
    end
  end

  always_comb begin
    unique case (state)
      ST_FB:                        mem_addr = pc_q + DW'(1);
      ST_FC:                        mem_addr = pc_q + DW'(2);
      ST_LA:                        mem_addr = a_q;
      ST_LB, ST_JMP, ST_NJMP, ST_IN: mem_addr = b_q;
      default:                      mem_addr = pc_q;
    endcase
    mem_wdata = (state == ST_IN) ? {{PAD{1'b0}}, in_byte} : res_q;
    mem_we    = (state == ST_JMP) | (state == ST_NJMP) |
                ((state == ST_IN) & in_valid);
    mem_a_val = ma_q;
    out_byte  = ma_q[BW-1:0];
    pc_neg    = pc_q[DW-1];
    a_neg1    = &a_q;
    b_neg1    = &b_q;
  end
endmodule

// File: rtl/oisc_core.sv
module oisc_core
  import oisc_pkg::*;
#(
  parameter int DW          = 16,
  parameter int BW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [DW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_we,
  input  logic [DW-1:0] mem_rdata,
  input  logic [BW-1:0] in_byte,
  input  logic          in_valid,
  output logic          in_ack,
  output logic [BW-1:0] out_byte,
  input  logic          out_busy,
  output logic          out_we,
  input  logic          pause,
  output logic          halted,
  output logic          blocked
);
  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   core_rst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[SYNC_STAGES-1];

  state_e        state;
  logic [DW-1:0] diff, mem_a_val;
  logic          diff_le, pc_neg, a_neg1, b_neg1;

  oisc_seq u_seq (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .pause    (pause),
    .pc_neg   (pc_neg),
    .a_neg1   (a_neg1),
    .b_neg1   (b_neg1),
    .diff_le  (diff_le),
    .in_valid (in_valid),
    .out_busy (out_busy),
    .state    (state),
    .in_ack   (in_ack),
    .out_we   (out_we),
    .blocked  (blocked),
    .halted   (halted)
  );

  oisc_datapath #(.DW(DW), .BW(BW)) u_dp (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .state     (state),
    .mem_rdata (mem_rdata),
    .in_byte   (in_byte),
    .in_valid  (in_valid),
    .diff      (diff),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_we    (mem_we),
    .mem_a_val (mem_a_val),
    .out_byte  (out_byte),
    .pc_neg    (pc_neg),
    .a_neg1    (a_neg1),
    .b_neg1    (b_neg1)
  );

  oisc_sub #(.DW(DW)) u_sub (
    .minuend    (mem_rdata),
    .subtrahend (mem_a_val),
    .diff       (diff),
    .le_zero    (diff_le)
  );
endmodule

// File: rtl/oisc_core_chk.sv
module oisc_core_chk (
  input logic clk,
  input logic rst_n,
  input logic mem_we,
  input logic in_valid,
  input logic in_ack,
  input logic out_busy,
  input logic out_we,
  input logic pause,
  input logic halted,
  input logic blocked
);
  // R4
  ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ack |=> !in_ack);
  // R5
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_we |=> !out_we);
  // R6
  halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);
  // R6
  halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> (!mem_we && !in_ack && !out_we));
  // R7
  stall_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blocked |-> (!mem_we && !out_we));
  // R8
  ack_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ack |-> in_valid);
  // R9
  strobe_needs_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_we |-> !out_busy);
  // R10
  halt_after_pause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halted) |-> !$past(pause));
endmodule

bind oisc_core oisc_core_chk u_chk (.*);

// File: tb/sim_oisc_core.sv
module sim_oisc_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] mem_addr, mem_wdata, mem_rdata;
  logic        mem_we;
  logic [7:0]  in_byte = 8'h00;
  logic        in_valid = 1'b0;
  logic        in_ack;
  logic [7:0]  out_byte;
  logic        out_busy = 1'b0;
  logic        out_we;
  logic        pause = 1'b0;
  logic        halted, blocked;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  oisc_core u0 (
    .clk(clk), .rst_n(rst_n),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
    .mem_rdata(mem_rdata),
    .in_byte(in_byte), .in_valid(in_valid), .in_ack(in_ack),
    .out_byte(out_byte), .out_busy(out_busy), .out_we(out_we),
    .pause(pause), .halted(halted), .blocked(blocked)
  );

  // behavioural memory, 256 words, address folded to 8 bits
  logic [15:0] mem [256];
  int wr_cnt, ack_cnt, out_cnt;
  logic [7:0] last_out;

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
    mem_rdata <= mem[mem_addr[7:0]];
    if (!rst_n) begin
      wr_cnt <= 0; ack_cnt <= 0; out_cnt <= 0; last_out <= 8'h00;
    end else begin
      if (mem_we) wr_cnt <= wr_cnt + 1;
      if (in_ack) ack_cnt <= ack_cnt + 1;
      if (out_we) begin
        out_cnt <= out_cnt + 1;
        last_out <= out_byte;
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    summary();
    $finish;
  end

  // clear memory, place halting tails: pc 3 marks -1, pc 20 marks -2
  task automatic load_base();
    for (int i = 0; i < 256; i++) mem[i] <= 16'h0000;
    mem[3] <= 16'd18; mem[4] <= 16'd17; mem[5] <= 16'hFFFF;
    mem[20] <= 16'd19; mem[21] <= 16'd17; mem[22] <= 16'hFFFF;
    mem[18] <= 16'd1; mem[19] <= 16'd2;
  endtask

  task automatic put_instr(input logic [15:0] a, input logic [15:0] b, input logic [15:0] c);
    mem[0] <= a; mem[1] <= b; mem[2] <= c;
  endtask

  task automatic enter_reset();
    @(negedge clk);
    rst_n = 1'b0;
  endtask

  task automatic leave_reset();
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wait_halt(input int limit, input string tag);
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (halted) return;
    end
    check(tag, {31'd0, halted}, 32'd1);
  endtask

  function automatic logic [15:0] pick(input int k);
    case (k)
      0: return 16'h0000;
      1: return 16'h0001;
      2: return 16'h0002;
      3: return 16'h7FFF;
      4: return 16'h8000;
      5: return 16'h8001;
      6: return 16'hFFFF;
      default: return 16'h00FF;
    endcase
  endfunction

  task automatic arith_vector(input logic [15:0] av, input logic [15:0] bv);
    logic [15:0] d;
    logic        le;
    d  = bv - av;
    le = d[15] | (d == 16'h0000);
    enter_reset();
    load_base();
    put_instr(16'd10, 16'd11, 16'd20);
    mem[10] <= av; mem[11] <= bv;
    leave_reset();
    wait_halt(60, "R6 halt after arithmetic");
    check("R2 difference", {16'd0, mem[11]}, {16'd0, d});
    check("R2 a unchanged", {16'd0, mem[10]}, {16'd0, av});
    check("R3 branch path", {16'd0, mem[17]}, {16'd0, le ? 16'hFFFE : 16'hFFFF});
  endtask

  initial begin
    logic [15:0] lf;
    int base;
    // R1 reset state
    repeat (2) @(negedge clk);
    load_base();
    put_instr(16'd10, 16'd11, 16'd20);
    @(negedge clk);
    check("R1 halted in reset", {31'd0, halted}, 32'd0);
    check("R1 blocked in reset", {31'd0, blocked}, 32'd0);
    check("R1 strobes in reset", {29'd0, mem_we, in_ack, out_we}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 first address", {16'd0, mem_addr}, 32'd0);
    wait_halt(60, "R1 run after reset");

    // R2 R3 sweep over corner values
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++)
        arith_vector(pick(i), pick(j));
    // R2 R3 pseudo-random operands
    lf = 16'hACE1;
    for (int k = 0; k < 64; k++) begin
      logic [15:0] x;
      lf = lf ^ (lf << 7); lf = lf ^ (lf >> 9); lf = lf ^ (lf << 8);
      x = lf;
      lf = lf ^ (lf << 7); lf = lf ^ (lf >> 9); lf = lf ^ (lf << 8);
      arith_vector(x, lf);
    end

    // R6 halt is absorbing and quiet
    base = wr_cnt;
    repeat (20) @(negedge clk);
    check("R6 still halted", {31'd0, halted}, 32'd1);
    check("R6 no writes after halt", base, wr_cnt);
    check("R6 no strobes after halt", ack_cnt + out_cnt, 0);

    // R8 then R4: input instruction a=0xFFFF, b=30, c=20
    enter_reset();
    load_base();
    put_instr(16'hFFFF, 16'd30, 16'd20);
    mem[30] <= 16'h5555;
    leave_reset();
    repeat (12) @(negedge clk);
    check("R8 blocked on input", {31'd0, blocked}, 32'd1);
    check("R8 no ack while empty", ack_cnt, 0);
    check("R8 no write while empty", wr_cnt, 0);
    in_byte = 8'hA5; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; in_byte = 8'h00;
    check("R8 released", {31'd0, blocked}, 32'd0);
    wait_halt(60, "R4 halt after input");
    check("R4 stored byte", {16'd0, mem[30]}, 32'h0000_00A5);
    check("R4 one ack", ack_cnt, 1);
    check("R4 no branch", {16'd0, mem[17]}, 32'h0000_FFFF);

    // R9 then R5: output instruction a=31, b=0xFFFF, c=20
    enter_reset();
    load_base();
    put_instr(16'd31, 16'hFFFF, 16'd20);
    mem[31] <= 16'h1234;
    out_busy = 1'b1;
    leave_reset();
    repeat (12) @(negedge clk);
    check("R9 blocked on output", {31'd0, blocked}, 32'd1);
    check("R9 no strobe while busy", out_cnt, 0);
    out_busy = 1'b0;
    wait_halt(60, "R5 halt after output");
    check("R5 one strobe", out_cnt, 1);
    check("R5 low byte", {24'd0, last_out}, 32'h0000_0034);
    check("R5 no memory write besides tail", wr_cnt, 1);
    check("R5 no branch", {16'd0, mem[17]}, 32'h0000_FFFF);
    check("R5 source unchanged", {16'd0, mem[31]}, 32'h0000_1234);

    // R7 pause holds the first fetch
    enter_reset();
    load_base();
    put_instr(16'd10, 16'd11, 16'd20);
    mem[10] <= 16'd3; mem[11] <= 16'd10;
    pause = 1'b1;
    leave_reset();
    repeat (10) @(negedge clk);
    check("R7 blocked while paused", {31'd0, blocked}, 32'd1);
    check("R7 fetch address held", {16'd0, mem_addr}, 32'd0);
    check("R7 no write while paused", wr_cnt, 0);
    check("R7 not halted", {31'd0, halted}, 32'd0);
    pause = 1'b0;
    wait_halt(60, "R7 resume");
    check("R7 result after resume", {16'd0, mem[11]}, 32'd7);

    // R10 pause meets negative pc at fetch
    enter_reset();
    load_base();
    put_instr(16'd12, 16'd12, 16'hFFFF);
    leave_reset();
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (mem_we) break;
    end
    pause = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check("R10 no halt during pause", {30'd0, halted, blocked}, 32'd1);
    end
    pause = 1'b0;
    @(negedge clk);
    check("R10 halt after release", {31'd0, halted}, 32'd1);

    summary();
    $finish;
  end
endmodule